// File: doc/BRIEF.md
# Rotate/Shift and Bit-Test Execution Unit

This unit carries out the eight single-bit rotate and shift operations of an 8-bit processor's prefixed group, and the single-bit test, on one byte operand. The operation class picks either a shift, which replaces the operand with its shifted value, or a bit test, which leaves the operand unchanged and reports the state of one selected bit in the flags. In both cases a new flag byte is formed from the incoming one.

Each accepted request is marked by a valid strobe. The result byte and the flag byte appear on registered outputs one clock later, with an output valid pulse. Between requests the outputs keep their last values. Instruction fetch, address generation and register write-back are handled elsewhere.

Flag byte layout, from bit 7 down to bit 0: sign S, zero Z, copy bit X5, half-carry H, copy bit X3, parity/overflow PV, subtract N, carry C.

Top module: `rsb_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high for the following cycle and `result`/`flags_out` show that request. When `in_valid` is low, `out_valid` is low in the following cycle.
- R2: While `rst_n` is low, `out_valid`, `result` and `flags_out` are all zero.
- R3: Rotate encodings for a shift (`op_bit`=0): `shift_sel`=0 rotates left, with old bit 7 going to both bit 0 and carry. `shift_sel`=1 rotates right, with old bit 0 going to both bit 7 and carry.
- R4: `shift_sel`=2 shifts left with the incoming carry (`flags_in[0]`) entering bit 0. `shift_sel`=3 shifts right with the incoming carry entering bit 7. In both, the bit shifted out becomes the new carry.
- R5: `shift_sel`=4 shifts left and fills bit 0 with 0. `shift_sel`=6 shifts left and fills bit 0 with 1. Both put the old bit 7 in carry.
- R6: `shift_sel`=7 shifts right and fills bit 7 with 0. `shift_sel`=5 shifts right and keeps bit 7. Both put the old bit 0 in carry.
- R7: After any shift, the flags are set from the result as follows: S is bit 7, Z is set when the result is zero, X5 and X3 are bits 5 and 3, and PV is set when the result has an even number of ones. C is the bit shifted out, and H and N are 0. `bit_idx` has no effect.
- R8: For a bit test (`op_bit`=1), `result` equals the operand. H is set, N is cleared and C equals the incoming carry. `shift_sel` has no effect.
- R9: For a bit test where the bit at `bit_idx` of the operand is 0, both Z and PV are set, and S, X5 and X3 are cleared.
- R10: For a bit test where the selected bit is 1, Z and PV are cleared. S is set only for index 7, X5 only for index 5, and X3 only for index 3. Only the selected bit of the operand decides the result, never the other bits.
- R11: A cycle without `in_valid` leaves `result` and `flags_out` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_bit | input | 1 | 0 = shift/rotate, 1 = bit test |
| shift_sel | input | 3 | Shift/rotate kind (R3 to R6) |
| bit_idx | input | 3 | Bit index for the test |
| operand | input | 8 | Operand byte |
| flags_in | input | 8 | Incoming flag byte |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 8 | Shifted byte, or operand for a bit test |
| flags_out | output | 8 | New flag byte |

## Verification
Every shift kind is run on single-bit, all-ones, all-zero and alternating operands. Each is tried with both carry-in values, so that the through-carry variants can be told apart from the plain rotates and from the fill-with-0 and fill-with-1 shifts. The bit test is run on each index, first with only the tested bit set and then with every other bit set. This shows that the test masks one bit rather than testing the whole operand for non-zero, and that S, X5 and X3 each appear only at their own index. Random operations, mixed with idle cycles that carry stray inputs, show that outputs hold and that the unused select fields are ignored.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SH_ROTL = 3'd0,
    SH_ROTR = 3'd1,
    SH_RCL  = 3'd2,
    SH_RCR  = 3'd3,
    SH_ASL  = 3'd4,
    SH_ASR  = 3'd5,
    SH_ONEL = 3'd6,
    SH_LSR  = 3'd7
  } shift_kind_e;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X3 = 3;
  localparam int FB_H  = 4;
  localparam int FB_X5 = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  function automatic logic even_ones(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction

  // flag byte produced by every shift/rotate
  function automatic logic [7:0] shift_flags(input logic [DATA_W-1:0] r,
                                             input logic cout);
    logic [7:0] f;
    f        = '0;
    f[FB_S]  = r[DATA_W-1];
    f[FB_Z]  = (r == '0);
    f[FB_X5] = r[5];
    f[FB_X3] = r[3];
    f[FB_PV] = even_ones(r);
    f[FB_C]  = cout;
    return f;
  endfunction

  // flag byte produced by the bit test
  function automatic logic [7:0] test_flags(input logic hit,
                                            input logic [IDX_W-1:0] idx,
                                            input logic cin);
    logic [7:0] f;
    f        = '0;
    f[FB_H]  = 1'b1;
    f[FB_C]  = cin;
    f[FB_Z]  = ~hit;
    f[FB_PV] = ~hit;
    f[FB_S]  = hit && (idx == IDX_W'(7));
    f[FB_X5] = hit && (idx == IDX_W'(5));
    f[FB_X3] = hit && (idx == IDX_W'(3));
    return f;
  endfunction

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
  import rsb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]     operand,
  input  shift_kind_e      kind,
  input  logic             carry_in,
  output logic [W-1:0]     shifted,
  output logic             carry_out,
  output logic             fill_bit,
  output logic             go_left
);

  // even encodings move towards bit W-1
  assign go_left = ~kind[0];

  always_comb begin
    unique case (kind)
      SH_ROTL: fill_bit = operand[W-1];
      SH_ROTR: fill_bit = operand[0];
      SH_RCL,
      SH_RCR:  fill_bit = carry_in;
      SH_ASL:  fill_bit = 1'b0;
      SH_ASR:  fill_bit = operand[W-1];
      SH_ONEL: fill_bit = 1'b1;
      SH_LSR:  fill_bit = 1'b0;
      default: fill_bit = 1'b0;
    endcase
  end

  assign shifted   = go_left ? {operand[W-2:0], fill_bit}
                             : {fill_bit, operand[W-1:1]};
  assign carry_out = go_left ? operand[W-1] : operand[0];

endmodule

// File: rtl/rsb_bit_tester.sv
module rsb_bit_tester
  import rsb_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [IW-1:0] bit_idx,
  output logic [W-1:0]  sel_mask,
  output logic          hit
);

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign sel_mask[i] = (bit_idx == IW'(i));
  end

  // bitwise masking, not a truth test of the whole operand
  assign hit = |(operand & sel_mask);

endmodule

// File: rtl/rsb_out_stage.sv
module rsb_out_stage #(
  parameter int W  = 8,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  d_result,
  input  logic [FW-1:0] d_flags,
  output logic          q_valid,
  output logic [W-1:0]  q_result,
  output logic [FW-1:0] q_flags
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_flags  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_result <= d_result;
        q_flags  <= d_flags;
      end
    end
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_bit,
  input  logic [SEL_W-1:0]  shift_sel,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags_out
);

  logic [DATA_W-1:0] sh_value;
  logic              sh_carry;
  logic              sh_fill;
  logic              sh_left;
  logic [DATA_W-1:0] test_mask;
  logic              test_hit;
  logic [DATA_W-1:0] next_result;
  logic [7:0]        next_flags;

  rsb_shifter #(.W(DATA_W)) u_shift (
    .operand   (operand),
    .kind      (shift_kind_e'(shift_sel)),
    .carry_in  (flags_in[FB_C]),
    .shifted   (sh_value),
    .carry_out (sh_carry),
    .fill_bit  (sh_fill),
    .go_left   (sh_left)
  );

  rsb_bit_tester #(.W(DATA_W), .IW(IDX_W)) u_test (
    .operand  (operand),
    .bit_idx  (bit_idx),
    .sel_mask (test_mask),
    .hit      (test_hit)
  );

  always_comb begin
    if (op_bit) begin
      next_result = operand;
      next_flags  = test_flags(test_hit, bit_idx, flags_in[FB_C]);
    end else begin
      next_result = sh_value;
      next_flags  = shift_flags(sh_value, sh_carry);
    end
  end

  rsb_out_stage #(.W(DATA_W), .FW(8)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid),
    .d_result (next_result),
    .d_flags  (next_flags),
    .q_valid  (out_valid),
    .q_result (result),
    .q_flags  (flags_out)
  );

endmodule

// File: rtl/rsb_unit_checker.sv
module rsb_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       op_bit,
  input logic [2:0] bit_idx,
  input logic [7:0] operand,
  input logic [7:0] flags_in,
  input logic       out_valid,
  input logic [7:0] result,
  input logic [7:0] flags_out,
  input logic       test_hit
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags_out)));

  a_r7_shift_hn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_bit) |=> (!flags_out[4] && !flags_out[1]));

  a_r7_shift_zero_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_bit) |=>
      ((flags_out[6] == (result == 8'h00)) && (flags_out[2] == ~(^result))
       && (flags_out[7] == result[7])));

  a_r8_test_keeps_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_bit) |=> (result == $past(operand)));

  a_r8_test_hnc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_bit) |=>
      (flags_out[4] && !flags_out[1] && (flags_out[0] == $past(flags_in[0]))));

  a_r9_clear_sets_zp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_bit && !operand[bit_idx]) |=>
      (flags_out[6] && flags_out[2] && !flags_out[7]));

  a_r10_hit_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_bit) |-> (test_hit == operand[bit_idx]));

  a_r10_set_sign_idx7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_bit && operand[bit_idx]) |=>
      (!flags_out[6] && (flags_out[7] == ($past(bit_idx) == 3'd7))));

endmodule

bind rsb_unit rsb_unit_checker u_rsb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_bit    (op_bit),
  .bit_idx   (bit_idx),
  .operand   (operand),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out),
  .test_hit  (test_hit)
);

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       op_bit = 1'b0;
  logic [2:0] shift_sel = 3'd0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] flags_in = 8'h00;
  logic       out_valid;
  logic [7:0] result;
  logic [7:0] flags_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rsb_unit u_rsb_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_bit    (op_bit),
    .shift_sel (shift_sel),
    .bit_idx   (bit_idx),
    .operand   (operand),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  // ---------------- reference model ----------------
  function automatic logic [8:0] ref_shift(input logic [2:0] k, input logic [7:0] v,
                                           input logic c);
    // returns {carry, value}
    case (k)
      3'd0: return {v[7], v[6:0], v[7]};
      3'd1: return {v[0], v[0], v[7:1]};
      3'd2: return {v[7], v[6:0], c};
      3'd3: return {v[0], c, v[7:1]};
      3'd4: return {v[7], v << 1};
      3'd5: return {v[0], v[7], v[7:1]};
      3'd6: return {v[7], (v << 1) | 8'h01};
      default: return {v[0], v >> 1};
    endcase
  endfunction

  function automatic logic [7:0] ref_shift_flags(input logic [7:0] r, input logic c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    return {r[7], (r == 8'h00), r[5], 1'b0, r[3], (ones % 2 == 0), 1'b0, c};
  endfunction

  function automatic logic [7:0] ref_test_flags(input logic [7:0] v, input logic [2:0] n,
                                                input logic c);
    logic b;
    b = (((v >> n) & 8'h01) != 8'h00);
    if (!b) return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, c};
    return {(n == 3'd7), 1'b0, (n == 3'd5), 1'b1, (n == 3'd3), 1'b0, 1'b0, c};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, check it at the next falling edge
  task automatic run_op(input string req, input logic ob, input logic [2:0] k,
                        input logic [2:0] n, input logic [7:0] v, input logic [7:0] f);
    logic [8:0] s;
    logic [7:0] er, ef;
    if (ob) begin
      er = v;
      ef = ref_test_flags(v, n, f[0]);
    end else begin
      s  = ref_shift(k, v, f[0]);
      er = s[7:0];
      ef = ref_shift_flags(s[7:0], s[8]);
    end
    in_valid = 1'b1; op_bit = ob; shift_sel = k; bit_idx = n; operand = v; flags_in = f;
    @(negedge clk);
    check({req, " R1 valid"}, {7'd0, out_valid}, 8'h01);
    check({req, " result"}, result, er);
    check({req, " flags"}, flags_out, ef);
    in_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    logic [7:0] pr, pf;
    pr = result; pf = flags_out;
    in_valid = 1'b0; op_bit = $urandom; shift_sel = $urandom; bit_idx = $urandom;
    operand = $urandom; flags_in = $urandom;
    @(negedge clk);
    check("R1 idle valid low", {7'd0, out_valid}, 8'h00);
    check("R11 result hold", result, pr);
    check("R11 flags hold", flags_out, pf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    check("R2 reset valid", {7'd0, out_valid}, 8'h00);
    check("R2 reset result", result, 8'h00);
    check("R2 reset flags", flags_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // directed shifts: every kind, both carries, corner operands
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 2; c++) begin
        string tag;
        tag = (k < 2) ? "R3" : (k < 4) ? "R4" : (k == 4 || k == 6) ? "R5" : "R6";
        run_op({tag, " R7"}, 1'b0, 3'(k), 3'd0, 8'h80, {7'd0, 1'(c)});
        run_op({tag, " R7"}, 1'b0, 3'(k), 3'd5, 8'h01, {7'h7f, 1'(c)});
        run_op({tag, " R7"}, 1'b0, 3'(k), 3'd2, 8'h00, {7'd0, 1'(c)});
        run_op({tag, " R7"}, 1'b0, 3'(k), 3'd7, 8'hff, {7'd0, 1'(c)});
        run_op({tag, " R7"}, 1'b0, 3'(k), 3'd1, 8'ha5, {7'h55, 1'(c)});
      end
    end
    idle_cycle();

    // directed bit tests: one-hot operand and its complement on each index
    for (int n = 0; n < 8; n++) begin
      run_op("R10 lone bit set", 1'b1, 3'(n + 1), 3'(n), 8'h01 << n, 8'h01);
      run_op("R9 others set", 1'b1, 3'(n), 3'(n), ~(8'h01 << n), 8'h00);
      run_op("R8 R9 zero operand", 1'b1, 3'd7, 3'(n), 8'h00, 8'hff);
      run_op("R10 all ones", 1'b1, 3'd2, 3'(n), 8'hff, 8'h00);
    end
    idle_cycle();

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 5) == 0) idle_cycle();
      else run_op("R7 R8 random", 1'($urandom), 3'($urandom), 3'($urandom),
                  8'($urandom), 8'($urandom));
    end
    idle_cycle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule